// File: doc/BRIEF.md
# Timer/Event Counter with Prescaler

An 8-bit up-counter for a small controller. It counts one of three things: ticks of a programmable divider on the system clock, edges on an external pin, or divider ticks for as long as that pin sits at its active level. When the counter passes its top value it reloads from a software-written preload value. It then raises a one-cycle interrupt request and flips a square-wave tone output, whose frequency is therefore half the overflow rate.

Software writes a control word (mode, divider select, polarity, run bit) and a preload byte. In pulse-width mode the block measures a single pulse. When the pin leaves its active level, the block clears its own run bit. The measured count then stays frozen until software arms the block again. External pin samples pass through a two-stage synchronizer before any edge or level decision.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0x00, the run bit is 0, the interrupt request is 0, the tone output is 0 and the preload value is 0x00.
- R2: A preload write while the run bit is 0 sets both the preload value and the count. A preload write while running changes only the preload value, and the count carries on unchanged.
- R3: In timer mode (mode 2'b10) with the run bit set, the count advances once every 2^(sel+1) system clocks, where sel is the 3-bit divider select (0..7). The first advance comes 2^(sel+1) clocks after the edge that writes the run bit.
- R4: When an advance occurs at count 0xFF, the count becomes the preload value and the interrupt request is high for exactly that one cycle. No other cycle raises it.
- R5: The tone output toggles on every overflow and at no other time.
- R6: In event mode (mode 2'b01) the count advances once per rising pin edge when the polarity bit is 0, and once per falling pin edge when it is 1. Edges of the other direction have no effect.
- R7: In pulse-width mode (mode 2'b11) the count advances on divider ticks only while the synchronized pin is at its active level: high for polarity 0, low for polarity 1. The divider restarts from zero whenever the pin is inactive.
- R8: In pulse-width mode, once the pin has been active and then returns inactive, the run bit clears by itself. The count holds even if the pin becomes active again.
- R9: With mode 2'b00, or with the run bit clear, the count does not change except through a preload write.
- R10: A control write with the run bit set re-arms pulse-width mode, so that one further pulse is measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| mode_i | input | 2 | Mode: 00 off, 01 event, 10 timer, 11 pulse width |
| psc_sel_i | input | 3 | Divider select, divide by 2^(sel+1) |
| pol_i | input | 1 | Edge / active-level polarity |
| run_i | input | 1 | Run bit value to write |
| load_we_i | input | 1 | Preload write strobe |
| load_data_i | input | 8 | Preload write data |
| ext_i | input | 1 | External event / gate pin |
| count_o | output | 8 | Current count |
| run_o | output | 1 | Current run bit |
| ovf_irq_o | output | 1 | One-cycle overflow interrupt request |
| pfd_o | output | 1 | Tone output, toggles on overflow |

## Verification
The assertions assume the inputs are driven from reset onward and are free of unknowns. They also assume a preload write is the only way the count may jump other than an overflow reload. The stimulus sets every pin level while the block is stopped and lets it settle for several cycles before arming. It holds each pin level for at least three clocks, so the synchronizer sees every transition. Random timer runs draw their preload, divider and duration from a fixed seed. Directed runs cover both polarities, the 0xFF preload and the pulse re-arm.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/evt_timer_psc.sv
module evt_timer_psc #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PW = 1 << SEL_W;

  logic [PW-1:0]  cnt_q;
  logic [SEL_W:0] sh;
  logic [PW-1:0]  mask;

  always_comb begin
    sh   = {1'b0, sel_i} + (SEL_W+1)'(1);
    mask = ~({PW{1'b1}} << sh);
  end

  assign tick_o = en_i && ((cnt_q | ~mask) == {PW{1'b1}});

  // restarts from zero whenever disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + PW'(1);
    else            cnt_q <= '0;
  end
endmodule

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o,
  output logic active_o
);
  logic [STAGES:0] sh_q;
  logic            cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign cur      = sh_q[STAGES-1];
  assign prev     = sh_q[STAGES];
  assign edge_o   = pol_i ? (prev & ~cur) : (cur & ~prev);
  assign active_o = cur ^ pol_i;
endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         pfd_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q, pfd_q;
  logic         wrap;

  assign wrap = step_i && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      pfd_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (wrap) pfd_q <= ~pfd_q;
      if (load_i)      cnt_q <= load_val_i;
      else if (wrap)   cnt_q <= reload_val_i;
      else if (step_i) cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign pfd_o = pfd_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int W      = 8,
  parameter int SEL_W  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             pol_i,
  input  logic             run_i,
  input  logic             load_we_i,
  input  logic [W-1:0]     load_data_i,
  input  logic             ext_i,
  output logic [W-1:0]     count_o,
  output logic             run_o,
  output logic             ovf_irq_o,
  output logic             pfd_o
);
  tmr_mode_e        mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             pol_q, run_q, seen_q;
  logic [W-1:0]     preload_q;
  logic             pin_edge, pin_active, tick, psc_en, step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      sel_q  <= '0;
      pol_q  <= 1'b0;
      run_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (ctrl_we_i) begin
      mode_q <= tmr_mode_e'(mode_i);
      sel_q  <= psc_sel_i;
      pol_q  <= pol_i;
      run_q  <= run_i;
      seen_q <= 1'b0;
    end else if (run_q && mode_q == MODE_PULSE) begin
      // one pulse only: disarm when the gate falls back
      if (pin_active)  seen_q <= 1'b1;
      else if (seen_q) run_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        preload_q <= '0;
    else if (load_we_i) preload_q <= load_data_i;
  end

  evt_timer_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(ext_i), .pol_i(pol_q),
    .edge_o(pin_edge), .active_o(pin_active)
  );

  assign psc_en = run_q && ((mode_q == MODE_TIMER) ||
                            (mode_q == MODE_PULSE && pin_active));

  evt_timer_psc #(.SEL_W(SEL_W)) u_psc (
    .clk_i, .rst_ni, .en_i(psc_en), .sel_i(sel_q), .tick_o(tick)
  );

  always_comb begin
    step = 1'b0;
    if (run_q) begin
      unique case (mode_q)
        MODE_EVENT:              step = pin_edge;
        MODE_TIMER, MODE_PULSE:  step = tick;
        default:                 step = 1'b0;
      endcase
    end
  end

  evt_timer_cnt #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step),
    .load_i(load_we_i && !run_q), .load_val_i(load_data_i),
    .reload_val_i(preload_q),
    .cnt_o(count_o), .ovf_o(ovf_irq_o), .pfd_o(pfd_o)
  );

  assign run_o = run_q;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ctrl_we_i,
  input logic         load_we_i,
  input logic [1:0]   mode_q,
  input logic [W-1:0] preload_q,
  input logic [W-1:0] count_o,
  input logic         run_o,
  input logic         ovf_irq_o,
  input logic         pfd_o
);
  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |=> !ovf_irq_o);

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> count_o == $past(preload_q));

  assert_irq_running_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> $past(run_o));

  assert_pfd_on_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pfd_o) |-> ovf_irq_o);

  assert_ovf_flips_pfd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> !$stable(pfd_o));

  assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(count_o) && !ovf_irq_o && !$past(load_we_i))
      |-> count_o == W'($past(count_o) + 1));

  assert_hold_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_o) && !$past(load_we_i)) |-> $stable(count_o));

  assert_self_disarm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(run_o) && !$past(ctrl_we_i)) |-> $past(mode_q) == 2'b11);
endmodule

bind evt_timer evt_timer_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .load_we_i(load_we_i),
  .mode_q(mode_q), .preload_q(preload_q), .count_o(count_o), .run_o(run_o),
  .ovf_irq_o(ovf_irq_o), .pfd_o(pfd_o)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       ctrl_we = 0, pol = 0, run = 0, load_we = 0, ext = 0;
  logic [1:0] mode = 0;
  logic [2:0] sel = 0;
  logic [7:0] load_data = 0;
  logic [7:0] count;
  logic       run_o, irq, pfd;
  int checks = 0, errors = 0, irq_seen = 0;
  bit done = 0;

  evt_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .mode_i(mode),
    .psc_sel_i(sel), .pol_i(pol), .run_i(run), .load_we_i(load_we),
    .load_data_i(load_data), .ext_i(ext), .count_o(count), .run_o(run_o),
    .ovf_irq_o(irq), .pfd_o(pfd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int p, input int ticks, output int c, output int ov);
    c = p; ov = 0;
    for (int i = 0; i < ticks; i++) begin
      if (c == 255) begin c = p; ov++; end
      else c++;
    end
  endfunction

  task automatic wr_ctrl(int m, int s, bit pl, bit r);
    @(negedge clk);
    ctrl_we = 1; mode = 2'(m); sel = 3'(s); pol = pl; run = r;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wr_load(int v);
    @(negedge clk);
    load_we = 1; load_data = 8'(v);
    @(negedge clk);
    load_we = 0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic timer_run(int p, int s, int n);
    int c, ov; bit pfd0;
    wr_load(p);
    pfd0 = pfd;
    wr_ctrl(2, s, 0, 1);
    irq_seen = 0;
    wait_n(n);
    model(p, n >> (s + 1), c, ov);
    chk("R3 timer count", count, c);
    chk("R4 overflow irqs", irq_seen, ov);
    chk("R5 tone level", pfd, pfd0 ^ ov[0]);
    wr_ctrl(2, s, 0, 0);
  endtask

  task automatic event_run(bit pl, int p, int k);
    int c, ov;
    wr_load(p);
    ext = pl;
    wait_n(5);
    wr_ctrl(1, 0, pl, 1);
    irq_seen = 0;
    repeat (k) begin
      ext = ~pl; wait_n(3);
      ext = pl;  wait_n(3);
    end
    wait_n(4);
    model(p, k, c, ov);
    chk(pl ? "R6 falling edges" : "R6 rising edges", count, c);
    chk("R4 event overflow irqs", irq_seen, ov);
    wr_ctrl(1, 0, pl, 0);
  endtask

  task automatic pulse_run(bit pl, int s, int len, int len2);
    int c, ov, held;
    wr_load(0);
    ext = pl;
    wait_n(5);
    wr_ctrl(3, s, pl, 1);
    wait_n(2);
    ext = ~pl; wait_n(len);
    ext = pl;  wait_n(6);
    model(0, len >> (s + 1), c, ov);
    chk("R7 pulse width count", count, c);
    chk("R8 run cleared", run_o, 0);
    held = count;
    ext = ~pl; wait_n(10);
    ext = pl;  wait_n(5);
    chk("R8 count held", count, held);
    chk("R8 stays disarmed", run_o, 0);
    wr_load(0);
    wr_ctrl(3, s, pl, 1);
    chk("R10 rearmed", run_o, 1);
    wait_n(2);
    ext = ~pl; wait_n(len2);
    ext = pl;  wait_n(6);
    model(0, len2 >> (s + 1), c, ov);
    chk("R10 second pulse count", count, c);
    chk("R10 disarmed again", run_o, 0);
  endtask

  initial begin
    void'($urandom(32'd91733));
    #(CLK_PERIOD * 3 + 2);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 run", run_o, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pfd", pfd, 0);
    rst_ni = 1;
    wait_n(2);
    chk("R1 still idle", count, 0);

    // R2: preload while stopped loads the count, while running it does not
    wr_load(8'h40);
    chk("R2 load while stopped", count, 8'h40);
    wr_ctrl(2, 7, 0, 1);
    wait_n(5);
    wr_load(8'h99);
    wait_n(5);
    chk("R2 load while running", count, 8'h40);
    wr_ctrl(2, 7, 0, 0);

    // R9: mode off with run set, and timer with run clear
    wr_load(8'h27);
    wr_ctrl(0, 0, 0, 1);
    ext = 1; wait_n(4); ext = 0; wait_n(20);
    chk("R9 mode off holds", count, 8'h27);
    wr_ctrl(2, 0, 0, 0);
    wait_n(20);
    chk("R9 run clear holds", count, 8'h27);

    // directed overflow corners
    timer_run(255, 0, 10);
    timer_run(250, 0, 40);
    timer_run(0, 7, 600);

    for (int i = 0; i < 25; i++)
      timer_run($urandom % 256, $urandom % 8, 1 + $urandom % 700);

    event_run(0, 8'h10, 7);
    event_run(1, 8'h10, 5);
    event_run(0, 8'hFE, 4);
    event_run(1, 8'hFF, 3);

    pulse_run(0, 0, 37, 12);
    pulse_run(1, 1, 50, 21);
    pulse_run(0, 2, 90, 33);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule